// File: doc/BRIEF.md
# Shadow RAM Segment Access Decoder

This block decides, for each memory cycle that lands in the upper BIOS window (0xC0000 to 0xFFFFF), whether the cycle is served by internal shadow DRAM or passed on to the external expansion bus. The decision depends on the cycle's address, its direction (read or write) and four byte-wide control registers. Software programs these registers through a small configuration port with a byte address, write data, a write strobe and read data.

The lower 192 KiB of the window is split into twelve 16 KiB segments. Each segment has its own read-enable bit and its own write-enable bit. The top 64 KiB is a single segment with one pair of enable bits. A set enable bit routes that direction to internal memory. A clear bit routes it to the external bus. Addresses below the window are flagged as out of range and never routed internally.

The decode is purely combinational from the access inputs and the current register contents. A configuration write updates the registers on the clock edge and therefore steers every access from the following cycle onward.

Top module: `shadow_seg_decoder`

## Requirements
- R1: After reset, all four control registers read back 0x00, and every in-range access in either direction is routed to the external bus (`acc_internal` = 0).
- R2: For 0xC0000 ≤ address < 0xF0000, the segment number is s = (address − 0xC0000) / 0x4000, giving 0 to 11. Segment s is governed by the register at configuration address 0x47 − floor(s/4). Segments 0–3 use 0x47, segments 4–7 use 0x46, and segments 8–11 use 0x45.
- R3: Within its governing register, segment s uses bit (s mod 4) to enable internal writes and bit (s mod 4) + 4 to enable internal reads. `acc_internal` equals the bit that matches the direction given by `acc_write` (1 = write).
- R4: For 0xF0000 ≤ address ≤ 0xFFFFF, writes follow bit 0 of register 0x44 and reads follow bit 1 of register 0x44.
- R5: A write to 0x44 stores only the bits in mask 0xCB (bits 7, 6, 3, 1, 0). Bits 5, 4 and 2 of 0x44 always read back as 0.
- R6: Writes to 0x45, 0x46 and 0x47 store all eight bits, and the value reads back unchanged.
- R7: Configuration reads of any address outside 0x44–0x47 return 0x00. Configuration writes to such addresses change neither any register nor any routing decision. With `cfg_we` low, no register changes.
- R8: For addresses below 0xC0000, `acc_in_range` = 0 and `acc_internal` = 0 regardless of register contents. Inside the window, `acc_in_range` = 1.
- R9: The decode outputs follow the access inputs and register contents combinationally. A configuration write takes effect on routing only after the clock edge that stores it, so an access in the same cycle still sees the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` (combinational) |
| acc_addr | input | 20 | Memory access address |
| acc_write | input | 1 | Access direction: 1 = write, 0 = read |
| acc_in_range | output | 1 | Access lies in 0xC0000–0xFFFFF |
| acc_internal | output | 1 | Access is served by internal shadow memory |

## Verification
A configuration write and a memory access can fall in the same cycle. The interesting case is when the write changes the very enable bit that the concurrent access depends on. The bench provokes this by writing the governing register while the access targets that segment. It expects the old routing during that cycle and the new routing on the next one, with its reference model updating register state only at the clock edge. Sweeps over all thirteen segments in both directions use several bit patterns, and the decode outputs are compared on every cycle.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  localparam int unsigned CFG_W       = 8;
  localparam int unsigned NUM_CTRL    = 4;
  localparam int unsigned SEG_PER_REG = 4;
  localparam int unsigned NUM_SEG     = 12;
  localparam int unsigned ACC_W       = 20;
  localparam int unsigned PAGE_LSB    = 14;
  localparam int unsigned PAGE_W      = ACC_W - PAGE_LSB;
  localparam int unsigned RD_OFFSET   = 4;
  localparam int unsigned TOP_WR_BIT  = 0;
  localparam int unsigned TOP_RD_BIT  = 1;
  localparam int unsigned TOP_REG     = 0;
  localparam logic [CFG_W-1:0] CTRL_BASE = 8'h44;
  localparam logic [CFG_W-1:0] TOP_MASK  = 8'hCB;

  typedef logic [NUM_CTRL-1:0][CFG_W-1:0] ctrl_bank_t;

  // register slot (0 = base address) that governs a 16 KiB segment
  function automatic int unsigned ctrl_slot(input int unsigned seg);
    return (seg / SEG_PER_REG) ^ (NUM_CTRL - 1);
  endfunction

  function automatic int unsigned wr_bit(input int unsigned seg);
    return seg % SEG_PER_REG;
  endfunction

  function automatic int unsigned rd_bit(input int unsigned seg);
    return (seg % SEG_PER_REG) + RD_OFFSET;
  endfunction

  // storage mask applied to a register slot
  function automatic logic [CFG_W-1:0] slot_mask(input int unsigned slot);
    return (slot == TOP_REG) ? TOP_MASK : {CFG_W{1'b1}};
  endfunction
endpackage

// File: rtl/shadow_ctrl_regs.sv
module shadow_ctrl_regs
  import shadow_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             cfg_we,
  output ctrl_bank_t       bank,
  output logic [CFG_W-1:0] cfg_rdata
);
  logic [NUM_CTRL-1:0] slot_hit;

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_slot
    localparam logic [CFG_W-1:0] SLOT_ADDR = CTRL_BASE + CFG_W'(g);
    localparam logic [CFG_W-1:0] SLOT_MASK = slot_mask(g);
    assign slot_hit[g] = (cfg_addr == SLOT_ADDR);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank[g] <= '0;
      end else if (cfg_we && slot_hit[g]) begin
        bank[g] <= cfg_wdata & SLOT_MASK;
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_CTRL; i++) begin
      if (slot_hit[i]) cfg_rdata = cfg_rdata | bank[i];
    end
  end
endmodule

// File: rtl/shadow_seg_map.sv
module shadow_seg_map
  import shadow_pkg::*;
(
  input  ctrl_bank_t        bank,
  input  logic [PAGE_W-1:0] acc_page,
  input  logic              acc_write,
  output logic              in_range,
  output logic              top_hit,
  output logic              acc_internal
);
  localparam int unsigned IDX_W   = PAGE_W - 2;
  localparam int unsigned VEC_LEN = 1 << IDX_W;

  logic [NUM_SEG-1:0] seg_wr_en;
  logic [NUM_SEG-1:0] seg_rd_en;
  logic [VEC_LEN-1:0] wr_vec;
  logic [VEC_LEN-1:0] rd_vec;
  logic [IDX_W-1:0]   seg_idx;
  logic               seg_sel;
  logic               top_sel;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    localparam int unsigned SLOT = ctrl_slot(g);
    localparam int unsigned WB   = wr_bit(g);
    localparam int unsigned RB   = rd_bit(g);
    assign seg_wr_en[g] = bank[SLOT][WB];
    assign seg_rd_en[g] = bank[SLOT][RB];
  end

  assign wr_vec  = {{(VEC_LEN-NUM_SEG){1'b0}}, seg_wr_en};
  assign rd_vec  = {{(VEC_LEN-NUM_SEG){1'b0}}, seg_rd_en};
  assign seg_idx = acc_page[IDX_W-1:0];

  assign in_range = &acc_page[PAGE_W-1:PAGE_W-2];
  assign top_hit  = in_range && (&acc_page[IDX_W-1:IDX_W-2]);

  assign seg_sel = acc_write ? wr_vec[seg_idx] : rd_vec[seg_idx];
  assign top_sel = acc_write ? bank[TOP_REG][TOP_WR_BIT] : bank[TOP_REG][TOP_RD_BIT];

  assign acc_internal = in_range && (top_hit ? top_sel : seg_sel);
endmodule

// File: rtl/shadow_seg_decoder.sv
module shadow_seg_decoder
  import shadow_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       cfg_addr,
  input  logic [7:0]       cfg_wdata,
  input  logic             cfg_we,
  output logic [7:0]       cfg_rdata,
  input  logic [19:0]      acc_addr,
  input  logic             acc_write,
  output logic             acc_in_range,
  output logic             acc_internal
);
  ctrl_bank_t        cfg_bank;
  logic              top_hit;
  logic [PAGE_W-1:0] acc_page;
  logic              unused_low;

  assign acc_page   = acc_addr[ACC_W-1:PAGE_LSB];
  assign unused_low = ^acc_addr[PAGE_LSB-1:0];

  shadow_ctrl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_we    (cfg_we),
    .bank      (cfg_bank),
    .cfg_rdata (cfg_rdata)
  );

  shadow_seg_map u_map (
    .bank         (cfg_bank),
    .acc_page     (acc_page),
    .acc_write    (acc_write),
    .in_range     (acc_in_range),
    .top_hit      (top_hit),
    .acc_internal (acc_internal)
  );
endmodule

// File: rtl/shadow_seg_decoder_chk.sv
module shadow_seg_decoder_chk
  import shadow_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  cfg_addr,
  input logic [7:0]  cfg_wdata,
  input logic        cfg_we,
  input logic [7:0]  cfg_rdata,
  input logic [19:0] acc_addr,
  input logic        acc_write,
  input logic        acc_in_range,
  input logic        acc_internal,
  input ctrl_bank_t  cfg_bank,
  input logic        top_hit
);
  AST_OUT_OF_RANGE_EXTERNAL: assert property (@(posedge clk) disable iff (!rst_n) !acc_in_range |-> !acc_internal); // R8
  AST_BELOW_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) (acc_addr < 20'hC0000) |-> !acc_in_range); // R8
  AST_MASKED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (cfg_addr == 8'h44) |-> ((cfg_rdata & ~TOP_MASK) == 8'h00)); // R5
  AST_OTHER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (cfg_addr < 8'h44 || cfg_addr > 8'h47) |-> (cfg_rdata == 8'h00)); // R7
  AST_FULL_STORE: assert property (@(posedge clk) disable iff (!rst_n) (cfg_we && cfg_addr == 8'h46) |=> (cfg_bank[2] == $past(cfg_wdata))); // R6
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !cfg_we |=> $stable(cfg_bank)); // R7
  AST_TOP_READ: assert property (@(posedge clk) disable iff (!rst_n) (top_hit && !acc_write) |-> (acc_internal == cfg_bank[0][1])); // R4
endmodule

bind shadow_seg_decoder shadow_seg_decoder_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_addr     (cfg_addr),
  .cfg_wdata    (cfg_wdata),
  .cfg_we       (cfg_we),
  .cfg_rdata    (cfg_rdata),
  .acc_addr     (acc_addr),
  .acc_write    (acc_write),
  .acc_in_range (acc_in_range),
  .acc_internal (acc_internal),
  .cfg_bank     (cfg_bank),
  .top_hit      (top_hit)
);

// File: tb/shadow_seg_decoder_bench.sv
`timescale 1ns/1ps
module shadow_seg_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_rdata;
  logic [19:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        acc_in_range;
  logic        acc_internal;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  int model [4];

  always #4 clk = ~clk;

  shadow_seg_decoder u_shadow_seg_decoder (.*);

  function automatic int exp_rdata(input int a);
    if (a >= 'h44 && a <= 'h47) return model[a - 'h44];
    return 0;
  endfunction

  function automatic int exp_range(input int a);
    return (a >= 'hC0000) ? 1 : 0;
  endfunction

  function automatic int exp_internal(input int a, input bit w);
    int seg, r, b;
    if (a < 'hC0000) return 0;
    if (a >= 'hF0000) return (model[0] >> (w ? 0 : 1)) & 1;
    seg = (a - 'hC0000) / 16384;
    r = 3 - seg / 4;
    b = seg % 4 + (w ? 0 : 4);
    return (model[r] >> b) & 1;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input int ca, input int wd, input bit we, input int aa, input bit aw, input string tag);
    @(negedge clk);
    cfg_addr = 8'(ca); cfg_wdata = 8'(wd); cfg_we = we;
    acc_addr = 20'(aa); acc_write = aw;
    #2;
    chk(tag, "cfg_rdata", int'(cfg_rdata), exp_rdata(ca));
    chk(tag, "acc_in_range", int'(acc_in_range), exp_range(aa));
    chk(tag, "acc_internal", int'(acc_internal), exp_internal(aa, aw));
    @(posedge clk);
    if (we) begin
      if (ca == 'h44) model[0] = wd & 'hCB;
      else if (ca >= 'h45 && ca <= 'h47) model[ca - 'h44] = wd & 'hFF;
    end
  endtask

  task automatic sweep(input string tag);
    for (int s = 0; s < 12; s++) begin
      step('h44 + (s % 4), 0, 0, 'hC0000 + s * 16384 + 'h1234, 1, tag);
      step('h44 + (s % 4), 0, 0, 'hC0000 + s * 16384 + 'h3FFF, 0, tag);
    end
    step('h44, 0, 0, 'hF0000, 1, "R4");
    step('h44, 0, 0, 'hFFFFF, 0, "R4");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int pats [4] = '{'h0F, 'hF0, 'hA5, 'h5A};
    for (int i = 0; i < 4; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 'h44; a <= 'h47; a++) step(a, 0, 0, 'hC0000 + (a - 'h44) * 'h14000, a[0], "R1");
    step('h44, 0, 0, 'hF8000, 0, "R1");

    // R9: same-cycle write and access; old value used, new value next cycle
    step('h47, 'h01, 1, 'hC0000, 1, "R9");
    step('h47, 0, 0, 'hC0000, 1, "R9");
    step('h45, 'h80, 1, 'hEC000, 0, "R9");
    step('h45, 0, 0, 'hEC000, 0, "R9");

    // R5: masked top register
    step('h44, 'hFF, 1, 'hF0000, 1, "R5");
    step('h44, 0, 0, 'hF0000, 1, "R5");
    step('h44, 'h34, 1, 'hF0000, 0, "R5");
    step('h44, 0, 0, 'hF0000, 0, "R5");

    // R6: full-width registers
    step('h45, 'hC3, 1, 0, 0, "R6");
    step('h46, 'h96, 1, 0, 0, "R6");
    step('h47, 'h7E, 1, 0, 0, "R6");
    for (int a = 'h45; a <= 'h47; a++) step(a, 0, 0, 0, 0, "R6");

    // R2 R3 R4: sweeps under several patterns
    for (int p = 0; p < 4; p++) begin
      for (int a = 'h44; a <= 'h47; a++) step(a, pats[p] ^ (a - 'h44), 1, 0, 0, "R6");
      sweep("R2 R3");
    end
    for (int s = 0; s < 12; s++) begin
      step('h47 - s / 4, 1 << (s % 4), 1, 0, 0, "R3");
      step('h00, 0, 0, 'hC0000 + s * 16384, 1, "R3");
      step('h00, 0, 0, 'hC0000 + s * 16384, 0, "R3");
    end

    // R8: below the window, with everything enabled
    for (int a = 'h44; a <= 'h47; a++) step(a, 'hFF, 1, 0, 0, "R8");
    step('h00, 0, 0, 'h00000, 1, "R8");
    step('h00, 0, 0, 'hBFFFF, 0, "R8");
    step('h00, 0, 0, 'h80000, 1, "R8");
    step('h00, 0, 0, 'hC0000, 0, "R8");

    // R7: writes elsewhere ignored; reads elsewhere zero
    step('h43, 'h00, 1, 'hC4000, 1, "R7");
    step('h48, 'h00, 1, 'hD0000, 0, "R7");
    step('h04, 'h00, 1, 'hF0000, 1, "R7");
    step('hC4, 'h00, 1, 'hE8000, 0, "R7");
    step('h43, 0, 0, 'hC4000, 1, "R7");
    step('h48, 0, 0, 'hD0000, 0, "R7");
    for (int a = 'h44; a <= 'h47; a++) step(a, 0, 0, 'hC0000 + (a - 'h44) * 'h10000, 1, "R7");

    finish_run();
  end
endmodule